// File: doc/BRIEF.md
# String Store Byte Sequencer

This block carries out an indexed multi-register string store, one byte per cycle. A start command names a first source register, a base register, an index register and a 7-bit byte count. The sequencer forms the target address, then walks through consecutive general-purpose registers. It emits each register's bytes to a memory write port, one byte per handshake, with the most significant byte first.

The block reads the register file through a single combinational read port. It reads the index register, then the base register, then each source word in turn. The memory port uses ready/valid flow control, and the block holds its request while the port is stalled. When the last byte is accepted, busy drops and done pulses for one cycle. A zero count produces no writes, and done pulses in the next cycle.

Top module: `strseq_store`

## Requirements
- R1: The first byte is written at address `reg[index] + (base == 0 ? 0 : reg[base])`, computed modulo 2^32. A base field of 0 contributes zero and never the contents of register 0. An index field of 0 does use register 0.
- R2: Each accepted byte advances the write address by exactly one. The address wraps from 0xFFFFFFFF to 0x00000000.
- R3: Within a register, bytes go out in this order: bits 31:24, then 23:16, then 15:8, then 7:0.
- R4: The first data register is the source field. After the fourth byte of a register, the walk moves to the next register number modulo 32, so register 31 is followed by register 0.
- R5: Exactly `count` byte writes are issued for counts 1 to 127. When the count is not a multiple of 4, the final register supplies only its leading bytes.
- R6: A start with count 0 issues no write and leaves busy low. Done is high in the cycle after the start edge.
- R7: While `mem_valid_o` is high and `mem_ready_i` is low, the request is held unchanged. The address, the data and the valid all stay as they are until a handshake occurs.
- R8: Busy is high from the cycle after an accepted nonzero start until the final handshake. A start pulse while busy has no effect on the byte stream.
- R9: Done is a single-cycle pulse. It is high in the cycle after the final handshake, and at that point busy is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| start_src_i | input | 5 | First source register number |
| start_base_i | input | 5 | Base register number, 0 means zero base |
| start_idx_i | input | 5 | Index register number |
| start_cnt_i | input | 7 | Number of bytes to store |
| rf_raddr_o | output | 5 | Register file read address |
| rf_rdata_i | input | 32 | Register file read data, combinational |
| mem_valid_o | output | 1 | Byte write request valid |
| mem_ready_i | input | 1 | Memory port accepts the request |
| mem_addr_o | output | 32 | Byte write address |
| mem_data_o | output | 8 | Byte write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps byte counts from 0 to 40, plus 127. It varies source registers so that the walk runs past register 31. A design that fails to wrap would read a wrong register, and one that ignores count remainders would emit extra bytes.

Operations with base 0 and index 0 catch a design that reads register 0 as the base. An index near 0xFFFFFFFF exposes address arithmetic that is narrower than 32 bits or saturates.

Randomised and alternating ready stalls expose a sequencer that advances without a handshake. Starts injected mid-operation catch a design that restarts instead of ignoring them.

// File: rtl/strseq_pkg.sv
// Package: shared constants and the sequencer state type.
// Assumes: 32-bit register file words made of 8-bit bytes.
package strseq_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_IDX  = 3'd1,
        ST_BASE = 3'd2,
        ST_LOAD = 3'd3,
        ST_SEND = 3'd4
    } seq_state_e;
endpackage

// File: rtl/strseq_ea.sv
// Module: strseq_ea
// Holds the base and index register numbers of an accepted command.
// Captures the index value during ST_IDX and presents the effective
// address during ST_BASE.
// Assumes: rf_rdata_i holds the base register while the state is ST_BASE.
module strseq_ea
    import strseq_pkg::*;
#(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [REG_AW-1:0] base_sel_i,
    input  logic [REG_AW-1:0] idx_sel_i,
    input  seq_state_e        state_i,
    input  logic [DATA_W-1:0] rf_rdata_i,
    output logic [REG_AW-1:0] base_sel_o,
    output logic [REG_AW-1:0] idx_sel_o,
    output logic [DATA_W-1:0] ea_o
);
    logic [REG_AW-1:0] base_q;
    logic [REG_AW-1:0] idx_q;
    logic [DATA_W-1:0] idx_val_q;
    logic [DATA_W-1:0] base_term;

    // Latch the register numbers of the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (accept_i) begin
            base_q <= base_sel_i;
            idx_q  <= idx_sel_i;
        end
    end

    // Capture the index register contents while it is addressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_val_q <= '0;
        end else if (state_i == ST_IDX) begin
            idx_val_q <= rf_rdata_i;
        end
    end

    // Base field zero means a constant zero term.
    always_comb begin
        base_term = (base_q == '0) ? '0 : rf_rdata_i;
        ea_o      = idx_val_q + base_term;
    end

    assign base_sel_o = base_q;
    assign idx_sel_o  = idx_q;
endmodule

// File: rtl/strseq_walk.sv
// Module: strseq_walk
// Walks registers and bytes. It tracks the current register number, the
// byte lane, the bytes remaining and the byte address, and it latches the
// current source word.
// Assumes: ack_i is asserted only while a byte request is being accepted.
module strseq_walk
    import strseq_pkg::*;
#(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [REG_AW-1:0] src_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              load_ea_i,
    input  logic [ADDR_W-1:0] ea_i,
    input  logic              load_word_i,
    input  logic [DATA_W-1:0] rf_rdata_i,
    input  logic              ack_i,
    output logic [REG_AW-1:0] reg_ptr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              last_byte_o,
    output logic              lane_last_o
);
    localparam int unsigned BPW    = DATA_W / BYTE_W;
    localparam int unsigned LANE_W = (BPW > 1) ? $clog2(BPW) : 1;

    logic [REG_AW-1:0] reg_ptr_q;
    logic [LANE_W-1:0] lane_q;
    logic [CNT_W-1:0]  remain_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] word_q;
    logic [BYTE_W-1:0] lane_bytes [BPW];

    // Register pointer: starts at the source field and steps mod 2^REG_AW.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_ptr_q <= '0;
        end else if (accept_i) begin
            reg_ptr_q <= src_i;
        end else if (ack_i && lane_last_o) begin
            reg_ptr_q <= reg_ptr_q + 1'b1;
        end
    end

    // Byte lane within the current word, most significant lane first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else if (accept_i) begin
            lane_q <= '0;
        end else if (ack_i) begin
            lane_q <= lane_last_o ? '0 : lane_q + 1'b1;
        end
    end

    // Bytes remaining in the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (accept_i) begin
            remain_q <= cnt_i;
        end else if (ack_i) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // Byte address: loaded with the effective address, then stepped by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_ea_i) begin
            addr_q <= ea_i;
        end else if (ack_i) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    // Source word latch, refreshed once per register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load_word_i) begin
            word_q <= rf_rdata_i;
        end
    end

    // Split the word into lanes, with lane 0 as the most significant byte.
    for (genvar g = 0; g < BPW; g++) begin : g_lane
        assign lane_bytes[g] = word_q[(BPW-1-g)*BYTE_W +: BYTE_W];
    end

    // Present the current byte and the end-of-walk flags.
    always_comb begin
        byte_o      = lane_bytes[lane_q];
        lane_last_o = (lane_q == LANE_W'(BPW - 1));
        last_byte_o = (remain_q == CNT_W'(1));
    end

    assign reg_ptr_o = reg_ptr_q;
    assign addr_o    = addr_q;

    // R2: the address advances by exactly one on every accepted byte.
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> addr_q == $past(addr_q) + 1'b1);

    // R4: the register pointer steps after the last lane of a word.
    a_r4_reg_next: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && lane_last_o) |=> reg_ptr_q == $past(reg_ptr_q) + 1'b1);

    // R5: every accepted byte consumes one unit of the count.
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> remain_q == $past(remain_q) - 1'b1);
endmodule

// File: rtl/strseq_ctrl.sv
// Module: strseq_ctrl
// Sequencer FSM. The states are idle, read index, read base, load word and
// send bytes. It produces the done pulse.
// Assumes: ack_i is a completed write handshake in ST_SEND.
module strseq_ctrl
    import strseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       cnt_zero_i,
    input  logic       ack_i,
    input  logic       last_byte_i,
    input  logic       lane_last_i,
    output seq_state_e state_o,
    output logic       accept_o,
    output logic       done_o
);
    seq_state_e state_q;
    seq_state_e state_d;
    logic       done_d;
    logic       done_q;

    // A start is taken only in idle.
    assign accept_o = start_i && (state_q == ST_IDLE);

    // Next-state and done decision.
    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_o) begin
                    if (cnt_zero_i) begin
                        done_d = 1'b1;
                    end else begin
                        state_d = ST_IDX;
                    end
                end
            end
            ST_IDX:  state_d = ST_BASE;
            ST_BASE: state_d = ST_LOAD;
            ST_LOAD: state_d = ST_SEND;
            ST_SEND: begin
                if (ack_i) begin
                    if (last_byte_i) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else if (lane_last_i) begin
                        state_d = ST_LOAD;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    assign state_o = state_q;
    assign done_o  = done_q;

    // R9: done never lasts two cycles.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R9: done arrives only with the sequencer back in idle.
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> state_q == ST_IDLE);

    // R6: a zero count finishes at once without leaving idle.
    a_r6_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && cnt_zero_i) |=> (done_q && state_q == ST_IDLE));
endmodule

// File: rtl/strseq_store.sv
// Module: strseq_store (top)
// Indexed string store: forms the effective address, then writes count
// bytes from consecutive registers, most significant byte first, one
// byte per memory handshake.
// Assumes: the register file read is combinational and its contents stay
// unchanged during an operation.
module strseq_store
    import strseq_pkg::*;
#(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REG_AW-1:0] start_src_i,
    input  logic [REG_AW-1:0] start_base_i,
    input  logic [REG_AW-1:0] start_idx_i,
    input  logic [CNT_W-1:0]  start_cnt_i,
    output logic [REG_AW-1:0] rf_raddr_o,
    input  logic [DATA_W-1:0] rf_rdata_i,
    output logic              mem_valid_o,
    input  logic              mem_ready_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_data_o,
    output logic              busy_o,
    output logic              done_o
);
    seq_state_e        state;
    logic              accept;
    logic              ack;
    logic              last_byte;
    logic              lane_last;
    logic [REG_AW-1:0] base_sel;
    logic [REG_AW-1:0] idx_sel;
    logic [REG_AW-1:0] reg_ptr;
    logic [DATA_W-1:0] ea;
    logic [DATA_W-1:0] ea_ext;

    strseq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cnt_zero_i  (start_cnt_i == '0),
        .ack_i       (ack),
        .last_byte_i (last_byte),
        .lane_last_i (lane_last),
        .state_o     (state),
        .accept_o    (accept),
        .done_o      (done_o)
    );

    strseq_ea #(
        .REG_AW (REG_AW),
        .DATA_W (DATA_W)
    ) u_ea (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .base_sel_i (start_base_i),
        .idx_sel_i  (start_idx_i),
        .state_i    (state),
        .rf_rdata_i (rf_rdata_i),
        .base_sel_o (base_sel),
        .idx_sel_o  (idx_sel),
        .ea_o       (ea)
    );

    // Fit the effective address to the address width.
    assign ea_ext = ea;

    strseq_walk #(
        .REG_AW (REG_AW),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .src_i       (start_src_i),
        .cnt_i       (start_cnt_i),
        .load_ea_i   (state == ST_BASE),
        .ea_i        (ADDR_W'(ea_ext)),
        .load_word_i (state == ST_LOAD),
        .rf_rdata_i  (rf_rdata_i),
        .ack_i       (ack),
        .reg_ptr_o   (reg_ptr),
        .addr_o      (mem_addr_o),
        .byte_o      (mem_data_o),
        .last_byte_o (last_byte),
        .lane_last_o (lane_last)
    );

    // Read port steering: the index first, then the base, then the data words.
    always_comb begin
        unique case (state)
            ST_IDX:  rf_raddr_o = idx_sel;
            ST_BASE: rf_raddr_o = base_sel;
            default: rf_raddr_o = reg_ptr;
        endcase
    end

    assign mem_valid_o = (state == ST_SEND);
    assign ack         = mem_valid_o && mem_ready_i;
    assign busy_o      = (state != ST_IDLE);

    // R7: a stalled request keeps its address, its data and its valid.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=>
            (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)));

    // R8: busy only drops together with a done pulse.
    a_r8_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
endmodule

// File: tb/strseq_store_tb_top.sv
// Bench: sweeps counts, register ranges, base/index choices and ready
// patterns, and compares every byte against an arithmetic model.
module strseq_store_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [4:0]  start_src_i;
    logic [4:0]  start_base_i;
    logic [4:0]  start_idx_i;
    logic [6:0]  start_cnt_i;
    logic [4:0]  rf_raddr_o;
    logic [31:0] rf_rdata_i;
    logic        mem_valid_o;
    logic        mem_ready_i;
    logic [31:0] mem_addr_o;
    logic [7:0]  mem_data_o;
    logic        busy_o;
    logic        done_o;

    logic [31:0] regs [32];
    int          vectors = 0;
    int          miscompares = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    assign rf_rdata_i = regs[rf_raddr_o];

    strseq_store dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_src_i  (start_src_i),
        .start_base_i (start_base_i),
        .start_idx_i  (start_idx_i),
        .start_cnt_i  (start_cnt_i),
        .rf_raddr_o   (rf_raddr_o),
        .rf_rdata_i   (rf_rdata_i),
        .mem_valid_o  (mem_valid_o),
        .mem_ready_i  (mem_ready_i),
        .mem_addr_o   (mem_addr_o),
        .mem_data_o   (mem_data_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // Ready pattern: 0 = always ready, 1 = pseudo-random, 2 = alternating.
    function automatic logic pick_ready(input int mode, input int cyc);
        if (mode == 0) return 1'b1;
        if (mode == 2) return cyc[0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic run_op(input int src, input int base, input int idx, input int cnt,
                          input logic [31:0] idx_val, input logic [31:0] base_val,
                          input int mode, input bit inject);
        logic [31:0] ea;
        logic [31:0] held_addr;
        logic [7:0]  held_data;
        logic [31:0] exp_word;
        logic [7:0]  exp_byte;
        int          k;
        int          cyc;
        bit          stalled;
        @(negedge clk);
        regs[idx] = idx_val;
        if (base != 0) regs[base] = base_val;
        ea = regs[idx] + ((base == 0) ? 32'h0 : regs[base]);
        start_i      = 1'b1;
        start_src_i  = 5'(src);
        start_base_i = 5'(base);
        start_idx_i  = 5'(idx);
        start_cnt_i  = 7'(cnt);
        @(negedge clk);
        start_i = 1'b0;
        if (cnt == 0) begin
            chk(done_o == 1'b1, "R6", "done after zero start", 32'(done_o), 32'h1);
            chk(busy_o == 1'b0, "R6", "busy on zero start", 32'(busy_o), 32'h0);
            chk(mem_valid_o == 1'b0, "R6", "write on zero start", 32'(mem_valid_o), 32'h0);
            @(negedge clk);
            chk(done_o == 1'b0, "R9", "zero done width", 32'(done_o), 32'h0);
            chk(mem_valid_o == 1'b0, "R6", "late write on zero", 32'(mem_valid_o), 32'h0);
            return;
        end
        chk(busy_o == 1'b1 && done_o == 1'b0, "R8", "busy after start",
            {busy_o, done_o}, 32'h2);
        k = 0;
        cyc = 0;
        stalled = 1'b0;
        held_addr = '0;
        held_data = '0;
        while (k < cnt && cyc < 3000) begin
            mem_ready_i = pick_ready(mode, cyc);
            if (inject && cyc == 3) begin
                start_i      = 1'b1;
                start_src_i  = 5'(src + 9);
                start_base_i = 5'(idx);
                start_idx_i  = 5'(base);
                start_cnt_i  = 7'd0;
            end else begin
                start_i = 1'b0;
            end
            if (busy_o !== 1'b1) chk(1'b0, "R8", "busy during op", 32'(busy_o), 32'h1);
            if (stalled) begin
                chk(mem_valid_o && mem_addr_o == held_addr && mem_data_o == held_data,
                    "R7", "stall hold", mem_addr_o, held_addr);
            end
            if (mem_valid_o) begin
                if (mem_ready_i) begin
                    exp_word = regs[(src + k / 4) % 32];
                    exp_byte = 8'(exp_word >> (24 - 8 * (k % 4)));
                    if (k == 0) chk(mem_addr_o == ea, "R1", "first address", mem_addr_o, ea);
                    else chk(mem_addr_o == ea + 32'(k), "R2", "byte address",
                             mem_addr_o, ea + 32'(k));
                    chk(mem_data_o == exp_byte, (k % 4 == 0 && k > 0) ? "R4" : "R3",
                        "byte data", 32'(mem_data_o), 32'(exp_byte));
                    k++;
                    stalled = 1'b0;
                end else begin
                    held_addr = mem_addr_o;
                    held_data = mem_data_o;
                    stalled = 1'b1;
                end
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        mem_ready_i = 1'b0;
        chk(k == cnt, "R5", "bytes before timeout", 32'(k), 32'(cnt));
        chk(done_o == 1'b1 && busy_o == 1'b0, "R9", "done after last byte",
            {busy_o, done_o}, 32'h1);
        chk(mem_valid_o == 1'b0, "R5", "extra byte request", 32'(mem_valid_o), 32'h0);
        @(negedge clk);
        chk(done_o == 1'b0, "R9", "done width", 32'(done_o), 32'h0);
        chk(mem_valid_o == 1'b0 && busy_o == 1'b0, "R8", "idle after op",
            {mem_valid_o, busy_o}, 32'h0);
    endtask

    // Watchdog: a hung run is one failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R8 watchdog: actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            regs[i] = {8'(8'h10 + i), 8'(8'h50 + i), 8'(8'h90 + i), 8'(8'hD0 + i)};
        end
        rst_n = 1'b0;
        start_i = 1'b0;
        start_src_i = '0;
        start_base_i = '0;
        start_idx_i = '0;
        start_cnt_i = '0;
        mem_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0 && mem_valid_o == 1'b0, "R8", "reset state",
            {busy_o, done_o, mem_valid_o}, 32'h0);

        // Sweep counts 0..40 over rotating registers, bases and ready patterns.
        for (int c = 0; c <= 40; c++) begin
            run_op((c * 7 + 20) % 32, c % 5, (c * 3 + 1) % 32, c,
                   32'h1000 + 32'(c * 37), 32'h20000 + 32'(c * 256), c % 3, c % 4 == 1);
        end
        // R1: base 0 and index 0 gives the contents of register 0 as the address.
        run_op(4, 0, 0, 6, 32'h0000_4440, 32'h0, 1, 1'b0);
        // R2: the address wraps through zero.
        run_op(29, 7, 9, 9, 32'hFFFF_FFF0, 32'h0000_000C, 0, 1'b0);
        // R4/R5: the maximum count starting at register 31 wraps the register numbers.
        run_op(31, 3, 2, 127, 32'h0000_8000, 32'h0000_0100, 1, 1'b1);
        // R5: a single byte from register 31.
        run_op(31, 0, 5, 1, 32'h0000_0777, 32'h0, 2, 1'b0);
        // R6: a zero count while the inputs are full of junk.
        run_op(31, 31, 31, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1'b0);

        report();
        $finish;
    end
endmodule